// File: doc/BRIEF.md
# Pin Boundary Scan Register Chain

This block is the boundary scan data register that sits around a set of bidirectional I/O pins. Every pin may own an input cell, an output cell and an output-enable cell; a per-pin mask picks which of these exist, so input-only and output-only pins take part with fewer cells. Besides the pin cells, the chain holds three fixed special cells: a test-output enable cell and a test-output value cell at the TDO end, and an update-flag cell at the TDI end.

A TAP controller outside the block supplies the capture, shift and update strobes and the current instruction mode. On a rising test clock edge the shift stage either captures the pin and core values or moves one place toward TDO. On a falling edge with the update strobe high, the update stage copies the shift stage. Under the external-test mode the update stage drives the pads and feeds the core's input; under sample/preload the core keeps the pads and sees the real pad input, while the chain can still be captured, shifted and preloaded.

Top module: `bsr_chain`

## Requirements
- R1: While rst_n_i is low at the clock edges, the shift stage and the update stage are cleared to zero, so tdo_o, tst_oe_o, tst_val_o and upd_flag_o read 0 and, in external-test mode, every pad output and enable with cells reads 0.
- R2: The chain has cell 0 = test-output enable, cell 1 = test-output value, then for each pin from 0 upward its present cells in the order input, output, enable, and the update-flag cell last; with the default masks (input cells on pins 0,1,3; output and enable cells on pins 0,1,2) the chain is 12 cells long and a bit entered on tdi_i reaches tdo_o after exactly 12 shifts.
- R3: On a rising edge with shift_i high and capture_i low, each cell takes the value of the cell above it, the last cell takes tdi_i, and tdo_o always shows cell 0.
- R4: On a rising edge with capture_i high (which wins over shift_i), input cells load pad_in_i, output cells load pad_out_o, enable cells load pad_oe_o, and the three special cells load their own update-stage values.
- R5: On a falling edge with update_i high the update stage loads the whole shift stage; otherwise it holds, so the pads do not change while shifting.
- R6: With mode_i = 1 (external test), a pin with output cells drives pad_out_o and pad_oe_o from its update-stage output and enable cells, and a pin with an input cell returns its update-stage input cell on core_in_o.
- R7: With mode_i = 0 (sample/preload), pad_out_o = core_out_i, pad_oe_o = core_oe_i and core_in_o = pad_in_i for every pin.
- R8: A pin without output cells always passes core_out_i and core_oe_i to its pad, and a pin without an input cell always returns pad_in_i on core_in_o, in both modes.
- R9: tst_oe_o, tst_val_o and upd_flag_o show the update-stage value of cell 0, cell 1 and the last cell respectively.
- R10: On a rising edge with both capture_i and shift_i low the shift stage holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 1 = external test, 0 = sample/preload |
| capture_i | input | 1 | Capture strobe (rising edge) |
| shift_i | input | 1 | Shift strobe (rising edge) |
| update_i | input | 1 | Update strobe (falling edge) |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, cell 0 |
| core_out_i | input | NUM_PINS | Core output value per pin |
| core_oe_i | input | NUM_PINS | Core output enable per pin |
| core_in_o | output | NUM_PINS | Input value returned to the core |
| pad_in_i | input | NUM_PINS | Value received from each pad |
| pad_out_o | output | NUM_PINS | Value driven to each pad |
| pad_oe_o | output | NUM_PINS | Output enable to each pad |
| tst_oe_o | output | 1 | Update-stage value of cell 0 |
| tst_val_o | output | 1 | Update-stage value of cell 1 |
| upd_flag_o | output | 1 | Update-stage value of the last cell |

## Verification
A capture or shift shows on tdo_o one rising edge after the strobe, and an update reaches the pads and special outputs at the falling edge in the middle of that same cycle; the pad and core_in_o muxing in either mode follows mode and core inputs with no register at all. The bench drives every input one nanosecond after a rising edge, so the following falling and rising edges both see it, and samples one nanosecond after the next rising edge, where a reference model has applied the update first and then the capture or shift. Directed sequences cover the reset state, the chain length, a preload followed by external test, and pads staying still during shifting, with random strobes, modes and pin values in between.

// File: rtl/bsr_pkg.sv
// Package: shared mode type and chain layout functions for the boundary
// scan register. Assumes at most MAX_PINS pins; masks are passed zero
// extended to MAX_PINS bits.
package bsr_pkg;

    localparam int MAX_PINS = 64;

    typedef enum logic {
        BSR_SAMPLE = 1'b0,
        BSR_EXTEST = 1'b1
    } bsr_mode_e;

    // Number of cells a pin owns: one for input, two for output and enable.
    function automatic int pin_cells(input int p, input logic [MAX_PINS-1:0] im,
                                     input logic [MAX_PINS-1:0] om);
        return (im[p] ? 1 : 0) + (om[p] ? 2 : 0);
    endfunction

    // Index of the first cell of pin p; two special cells come first.
    function automatic int pin_base(input int p, input logic [MAX_PINS-1:0] im,
                                    input logic [MAX_PINS-1:0] om);
        int b;
        b = 2;
        for (int q = 0; q < p; q++) b += pin_cells(q, im, om);
        return b;
    endfunction

    // Total chain length including the final update-flag cell.
    function automatic int chain_len(input int n, input logic [MAX_PINS-1:0] im,
                                     input logic [MAX_PINS-1:0] om);
        return pin_base(n, im, om) + 1;
    endfunction

    // Output cell follows the input cell when that exists.
    function automatic int out_idx(input int p, input logic [MAX_PINS-1:0] im,
                                   input logic [MAX_PINS-1:0] om);
        return pin_base(p, im, om) + (im[p] ? 1 : 0);
    endfunction

endpackage

// File: rtl/bsr_shift_stage.sv
// Module: capture/shift stage of the chain. Captures a parallel vector or
// shifts one place toward cell 0 on the rising test clock. Assumes the
// strobes are stable around the rising edge; capture wins over shift.
module bsr_shift_stage #(
    parameter int LEN = 12
) (
    input  logic           tck_i,
    input  logic           rst_n_i,
    input  logic           capture_i,
    input  logic           shift_i,
    input  logic           tdi_i,
    input  logic [LEN-1:0] cap_vec_i,
    output logic [LEN-1:0] sr_o
);

    logic [LEN-1:0] sr_q;

    // Capture, shift toward TDO, or hold.
    always_ff @(posedge tck_i) begin
        if (!rst_n_i) begin
            sr_q <= '0;
        end else if (capture_i) begin
            sr_q <= cap_vec_i;
        end else if (shift_i) begin
            sr_q <= {tdi_i, sr_q[LEN-1:1]};
        end
    end

    assign sr_o = sr_q;

endmodule

// File: rtl/bsr_update_stage.sv
// Module: update stage of the chain. Copies the shift stage on the falling
// test clock edge when update is strobed, and holds otherwise. Assumes the
// update strobe is stable around the falling edge.
module bsr_update_stage #(
    parameter int LEN = 12
) (
    input  logic           tck_i,
    input  logic           rst_n_i,
    input  logic           update_i,
    input  logic [LEN-1:0] sr_i,
    output logic [LEN-1:0] upd_o
);

    logic [LEN-1:0] upd_q;

    // Load from the shift stage on the falling edge.
    always_ff @(negedge tck_i) begin
        if (!rst_n_i) begin
            upd_q <= '0;
        end else if (update_i) begin
            upd_q <= sr_i;
        end
    end

    assign upd_o = upd_q;

endmodule

// File: rtl/bsr_pin_mux.sv
// Module: per-pin steering between core and update stage. The select
// inputs already include the pin's cell mask; a pin with an absent cell
// has its select tied low so the core or pad path is always taken.
module bsr_pin_mux (
    input  logic ext_out_sel_i,
    input  logic ext_in_sel_i,
    input  logic upd_out_i,
    input  logic upd_oe_i,
    input  logic upd_in_i,
    input  logic core_out_i,
    input  logic core_oe_i,
    input  logic pad_in_i,
    output logic pad_out_o,
    output logic pad_oe_o,
    output logic core_in_o
);

    // Pad drive and core input selection.
    always_comb begin
        pad_out_o = ext_out_sel_i ? upd_out_i : core_out_i;
        pad_oe_o  = ext_out_sel_i ? upd_oe_i  : core_oe_i;
        core_in_o = ext_in_sel_i  ? upd_in_i  : pad_in_i;
    end

endmodule

// File: rtl/bsr_chain.sv
// Module: boundary scan register chain for NUM_PINS I/O pins. Cell 0 and
// cell 1 are the test-output enable and value cells, the last cell is the
// update flag; pin cells lie between in input, output, enable order.
// Assumes an external TAP controller produces the strobes and the mode.
module bsr_chain #(
    parameter int                  NUM_PINS = 4,
    parameter logic [NUM_PINS-1:0] IN_MASK  = 4'b1011,
    parameter logic [NUM_PINS-1:0] OUT_MASK = 4'b0111
) (
    input  logic                tck_i,
    input  logic                rst_n_i,
    input  logic                mode_i,
    input  logic                capture_i,
    input  logic                shift_i,
    input  logic                update_i,
    input  logic                tdi_i,
    output logic                tdo_o,
    input  logic [NUM_PINS-1:0] core_out_i,
    input  logic [NUM_PINS-1:0] core_oe_i,
    output logic [NUM_PINS-1:0] core_in_o,
    input  logic [NUM_PINS-1:0] pad_in_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic                tst_oe_o,
    output logic                tst_val_o,
    output logic                upd_flag_o
);
    import bsr_pkg::*;

    localparam logic [MAX_PINS-1:0] IM  = MAX_PINS'(IN_MASK);
    localparam logic [MAX_PINS-1:0] OM  = MAX_PINS'(OUT_MASK);
    localparam int                  LEN = chain_len(NUM_PINS, IM, OM);

    bsr_mode_e      mode;
    logic           extest;
    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] upd_q;
    logic [LEN-1:0] cap_vec;

    assign mode   = bsr_mode_e'(mode_i);
    assign extest = (mode == BSR_EXTEST);

    // Special cells capture their own update-stage values.
    assign cap_vec[0]     = upd_q[0];
    assign cap_vec[1]     = upd_q[1];
    assign cap_vec[LEN-1] = upd_q[LEN-1];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int BASE = pin_base(p, IM, OM);
        localparam int OIX  = out_idx(p, IM, OM);
        logic ext_out_sel;
        logic ext_in_sel;
        logic upd_out;
        logic upd_oe;
        logic upd_in;

        if (OUT_MASK[p]) begin : g_out
            assign ext_out_sel    = extest;
            assign upd_out        = upd_q[OIX];
            assign upd_oe         = upd_q[OIX+1];
            assign cap_vec[OIX]   = pad_out_o[p];
            assign cap_vec[OIX+1] = pad_oe_o[p];
        end else begin : g_no_out
            assign ext_out_sel = 1'b0;
            assign upd_out     = 1'b0;
            assign upd_oe      = 1'b0;
        end

        if (IN_MASK[p]) begin : g_in
            assign ext_in_sel    = extest;
            assign upd_in        = upd_q[BASE];
            assign cap_vec[BASE] = pad_in_i[p];
        end else begin : g_no_in
            assign ext_in_sel = 1'b0;
            assign upd_in     = 1'b0;
        end

        bsr_pin_mux mux_i (
            .ext_out_sel_i (ext_out_sel),
            .ext_in_sel_i  (ext_in_sel),
            .upd_out_i     (upd_out),
            .upd_oe_i      (upd_oe),
            .upd_in_i      (upd_in),
            .core_out_i    (core_out_i[p]),
            .core_oe_i     (core_oe_i[p]),
            .pad_in_i      (pad_in_i[p]),
            .pad_out_o     (pad_out_o[p]),
            .pad_oe_o      (pad_oe_o[p]),
            .core_in_o     (core_in_o[p])
        );
    end

    bsr_shift_stage #(.LEN(LEN)) shift_i_u (
        .tck_i     (tck_i),
        .rst_n_i   (rst_n_i),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .tdi_i     (tdi_i),
        .cap_vec_i (cap_vec),
        .sr_o      (sr_q)
    );

    bsr_update_stage #(.LEN(LEN)) update_u (
        .tck_i    (tck_i),
        .rst_n_i  (rst_n_i),
        .update_i (update_i),
        .sr_i     (sr_q),
        .upd_o    (upd_q)
    );

    assign tdo_o      = sr_q[0];
    assign tst_oe_o   = upd_q[0];
    assign tst_val_o  = upd_q[1];
    assign upd_flag_o = upd_q[LEN-1];

endmodule

// File: rtl/bsr_chain_chk.sv
// Module: assertion checker for bsr_chain, bound to every instance.
// Assumes strobes change away from both clock edges.
module bsr_chain_chk #(
    parameter int                  NUM_PINS = 4,
    parameter logic [NUM_PINS-1:0] IN_MASK  = 4'b1011,
    parameter logic [NUM_PINS-1:0] OUT_MASK = 4'b0111,
    parameter int                  LEN      = 12
) (
    input logic                tck_i,
    input logic                rst_n_i,
    input logic                mode_i,
    input logic                capture_i,
    input logic                shift_i,
    input logic                update_i,
    input logic                tdi_i,
    input logic [NUM_PINS-1:0] core_out_i,
    input logic [NUM_PINS-1:0] core_oe_i,
    input logic [NUM_PINS-1:0] core_in_o,
    input logic [NUM_PINS-1:0] pad_in_i,
    input logic [NUM_PINS-1:0] pad_out_o,
    input logic [NUM_PINS-1:0] pad_oe_o,
    input logic                tst_oe_o,
    input logic [LEN-1:0]      sr_q,
    input logic [LEN-1:0]      upd_q
);
    import bsr_pkg::*;

    localparam logic [MAX_PINS-1:0] IM = MAX_PINS'(IN_MASK);
    localparam logic [MAX_PINS-1:0] OM = MAX_PINS'(OUT_MASK);

    a_r3_shift_moves: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        (shift_i && !capture_i) |=> (sr_q == {$past(tdi_i), $past(sr_q[LEN-1:1])}));

    a_r10_idle_holds: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        (!shift_i && !capture_i) |=> $stable(sr_q));

    a_r5_update_holds: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        !update_i |-> $stable(upd_q));

    a_r5_update_loads: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        update_i |-> (upd_q == sr_q));

    a_r9_special_out: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        update_i |-> (tst_oe_o == sr_q[0]));

    a_r7_sample_pads: assert property (@(posedge tck_i) disable iff (!rst_n_i)
        !mode_i |-> (pad_out_o == core_out_i && pad_oe_o == core_oe_i
                     && core_in_o == pad_in_i));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
        localparam int BASE = pin_base(p, IM, OM);
        localparam int OIX  = out_idx(p, IM, OM);
        if (IN_MASK[p]) begin : g_in
            a_r4_capture_in: assert property (@(posedge tck_i) disable iff (!rst_n_i)
                capture_i |=> (sr_q[BASE] == $past(pad_in_i[p])));
            a_r6_extest_in: assert property (@(posedge tck_i) disable iff (!rst_n_i)
                mode_i |-> (core_in_o[p] == upd_q[BASE]));
        end else begin : g_no_in
            a_r8_pass_in: assert property (@(posedge tck_i) disable iff (!rst_n_i)
                1'b1 |-> (core_in_o[p] == pad_in_i[p]));
        end
        if (OUT_MASK[p]) begin : g_out
            a_r4_capture_out: assert property (@(posedge tck_i) disable iff (!rst_n_i)
                capture_i |=> (sr_q[OIX] == $past(pad_out_o[p])));
            a_r6_extest_out: assert property (@(posedge tck_i) disable iff (!rst_n_i)
                mode_i |-> (pad_out_o[p] == upd_q[OIX] && pad_oe_o[p] == upd_q[OIX+1]));
        end else begin : g_no_out
            a_r8_pass_out: assert property (@(posedge tck_i) disable iff (!rst_n_i)
                1'b1 |-> (pad_out_o[p] == core_out_i[p] && pad_oe_o[p] == core_oe_i[p]));
        end
    end

endmodule

bind bsr_chain bsr_chain_chk #(
    .NUM_PINS (NUM_PINS),
    .IN_MASK  (IN_MASK),
    .OUT_MASK (OUT_MASK),
    .LEN      (LEN)
) chk_i (
    .tck_i      (tck_i),
    .rst_n_i    (rst_n_i),
    .mode_i     (mode_i),
    .capture_i  (capture_i),
    .shift_i    (shift_i),
    .update_i   (update_i),
    .tdi_i      (tdi_i),
    .core_out_i (core_out_i),
    .core_oe_i  (core_oe_i),
    .core_in_o  (core_in_o),
    .pad_in_i   (pad_in_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o),
    .tst_oe_o   (tst_oe_o),
    .sr_q       (sr_q),
    .upd_q      (upd_q)
);

// File: tb/bsr_chain_tb_top.sv
// Bench: random and directed stimulus for bsr_chain with default masks,
// compared against a reference model built from the requirements.
module bsr_chain_tb_top;

    localparam int N   = 4;
    localparam int LEN = 12;
    // Layout from R2 with input cells on pins 0,1,3, output cells on 0,1,2.
    localparam int IN_POS [N]  = '{2, 5, -1, 10};
    localparam int OUT_POS [N] = '{3, 6, 8, -1};

    logic         tck_i = 1'b0;
    logic         rst_n_i = 1'b0;
    logic         mode_i = 1'b0;
    logic         capture_i = 1'b0;
    logic         shift_i = 1'b0;
    logic         update_i = 1'b0;
    logic         tdi_i = 1'b0;
    logic         tdo_o;
    logic [N-1:0] core_out_i = '0;
    logic [N-1:0] core_oe_i = '0;
    logic [N-1:0] core_in_o;
    logic [N-1:0] pad_in_i = '0;
    logic [N-1:0] pad_out_o;
    logic [N-1:0] pad_oe_o;
    logic         tst_oe_o;
    logic         tst_val_o;
    logic         upd_flag_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [LEN-1:0] m_sr  = '0;
    logic [LEN-1:0] m_upd = '0;

    always #2 tck_i = ~tck_i;

    bsr_chain dut_i (
        .tck_i(tck_i), .rst_n_i(rst_n_i), .mode_i(mode_i),
        .capture_i(capture_i), .shift_i(shift_i), .update_i(update_i),
        .tdi_i(tdi_i), .tdo_o(tdo_o),
        .core_out_i(core_out_i), .core_oe_i(core_oe_i), .core_in_o(core_in_o),
        .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
        .tst_oe_o(tst_oe_o), .tst_val_o(tst_val_o), .upd_flag_o(upd_flag_o)
    );

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_pad_out(input int p);
        return (mode_i && OUT_POS[p] >= 0) ? m_upd[OUT_POS[p]] : core_out_i[p];
    endfunction
    function automatic logic exp_pad_oe(input int p);
        return (mode_i && OUT_POS[p] >= 0) ? m_upd[OUT_POS[p]+1] : core_oe_i[p];
    endfunction
    function automatic logic exp_core_in(input int p);
        return (mode_i && IN_POS[p] >= 0) ? m_upd[IN_POS[p]] : pad_in_i[p];
    endfunction

    // Compare every output against the model.
    task automatic check_all(input string tdo_tag);
        check(tdo_tag, "tdo", tdo_o, m_sr[0]);
        check("R9", "tst_oe", tst_oe_o, m_upd[0]);
        check("R9", "tst_val", tst_val_o, m_upd[1]);
        check("R9", "upd_flag", upd_flag_o, m_upd[LEN-1]);
        for (int p = 0; p < N; p++) begin
            string ot;
            string it;
            ot = (OUT_POS[p] < 0) ? "R8" : (mode_i ? "R6" : "R7");
            it = (IN_POS[p] < 0) ? "R8" : (mode_i ? "R6" : "R7");
            check(ot, $sformatf("pad_out[%0d]", p), pad_out_o[p], exp_pad_out(p));
            check(ot, $sformatf("pad_oe[%0d]", p), pad_oe_o[p], exp_pad_oe(p));
            check(it, $sformatf("core_in[%0d]", p), core_in_o[p], exp_core_in(p));
        end
    endtask

    // One test clock cycle: drive strobes, update model, check after edge.
    task automatic tick(input bit c, input bit s, input bit u, input bit t);
        logic [LEN-1:0] cap;
        capture_i = c; shift_i = s; update_i = u; tdi_i = t;
        @(posedge tck_i);
        if (!rst_n_i) begin
            m_sr = '0; m_upd = '0;
        end else begin
            if (u) m_upd = m_sr;
            cap = m_upd;
            for (int p = 0; p < N; p++) begin
                if (IN_POS[p] >= 0) cap[IN_POS[p]] = pad_in_i[p];
                if (OUT_POS[p] >= 0) begin
                    cap[OUT_POS[p]]   = exp_pad_out(p);
                    cap[OUT_POS[p]+1] = exp_pad_oe(p);
                end
            end
            if (c) m_sr = cap;
            else if (s) m_sr = {t, m_sr[LEN-1:1]};
        end
        #1;
        check_all(!rst_n_i ? "R1" : c ? "R4" : s ? "R3" : "R10");
    endtask

    task automatic randomize_pins();
        core_out_i = N'($urandom);
        core_oe_i  = N'($urandom);
        pad_in_i   = N'($urandom);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        // R1: reset clears both stages; check in external-test mode.
        mode_i = 1'b1;
        @(posedge tck_i); #1;
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b1, 1'b1);
        check("R1", "tdo after reset", tdo_o, 1'b0);
        check("R1", "pad_oe[0] after reset", pad_oe_o[0], 1'b0);
        rst_n_i = 1'b1;

        // R2: a single one reaches tdo after exactly LEN shifts.
        tick(1'b0, 1'b1, 1'b0, 1'b1);
        for (int i = 1; i < LEN - 1; i++) tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R2", "tdo after LEN-1 shifts", tdo_o, 1'b0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R2", "tdo after LEN shifts", tdo_o, 1'b1);

        // Preload in sample mode: pin 0 out=1 oe=1, pin 2 out=1 oe=0, flag=1.
        mode_i = 1'b0;
        begin
            logic [LEN-1:0] pat;
            pat = '0;
            pat[3] = 1'b1; pat[4] = 1'b1; pat[8] = 1'b1; pat[LEN-1] = 1'b1; pat[2] = 1'b1;
            for (int i = 0; i < LEN; i++) tick(1'b0, 1'b1, 1'b0, pat[i]);
        end
        core_out_i = '0; core_oe_i = '0;
        tick(1'b0, 1'b0, 1'b1, 1'b0);
        check("R7", "pad_out[0] sample after preload", pad_out_o[0], 1'b0);
        mode_i = 1'b1;
        #1;
        check("R6", "pad_out[0] extest", pad_out_o[0], 1'b1);
        check("R6", "pad_oe[0] extest", pad_oe_o[0], 1'b1);
        check("R6", "pad_out[2] extest", pad_out_o[2], 1'b1);
        check("R6", "core_in[0] extest", core_in_o[0], 1'b1);
        check("R9", "upd_flag after preload", upd_flag_o, 1'b1);
        // R5: shifting without update leaves the pads alone.
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 1'b1, 1'b0, 1'b0);
            check("R5", "pad_out[0] held while shifting", pad_out_o[0], 1'b1);
        end

        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 16) == 0) mode_i = ~mode_i;
            randomize_pins();
            tick(($urandom % 5) == 0, ($urandom % 2) == 0,
                 ($urandom % 4) == 0, 1'($urandom));
        end

        // R4: capture wins over shift.
        mode_i = 1'b0;
        pad_in_i = 4'b0001;
        tick(1'b1, 1'b1, 1'b0, 1'b0);
        check("R4", "pin 0 input cell via tdo after 2 shifts", m_sr[2], 1'b1);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b1, 1'b0, 1'b0);
        check("R4", "tdo shows captured pad_in[0]", tdo_o, 1'b1);

        finish_run();
    end

endmodule